// File: doc/BRIEF.md
# BCD Calendar Counter with Leap-Year Handling

This block keeps wall-clock time and calendar date in packed BCD. It holds seconds, minutes, 24-hour hours, a weekday numbered 1 to 7, day of month, month and a two-digit year. It advances all of them once per second. Month lengths and leap years are applied automatically. The weekday steps on every midnight and wraps on its own, with no tie to the date.

A built-in divider turns a 32.768 kHz enable into a one-second tick. The upper stages of the divider, from 128 Hz down to 1 Hz, can be cleared from outside so that a write starts a fresh second. A hold input keeps the tick from reaching the counters while a write is in progress. A parallel load commits a complete time-and-date word in one cycle. The present state is always visible as a 52-bit word in serial frame order, so a surrounding serial engine can shift it out or in.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the word reads 00:00:00, weekday 1, day 1, month 1, year 00.
- R2: Seconds and minutes count in BCD from 00 to 59 (09 steps to 10). At 59 they wrap to 00 and carry into the next field.
- R3: Hours count 00 to 23. The carry out of 23:59:59 returns the time to 00:00:00 and advances the date by one day.
- R4: The weekday increments on each day rollover and wraps from 7 to 1, whatever the date.
- R5: After the last day of a month the day returns to 01 and the month advances. Months 04, 06, 09 and 11 end on day 30, and months 01, 03, 05, 07, 08, 10 and 12 end on day 31.
- R6: February ends on day 29 when the year is divisible by 4 (even tens digit with ones 0/4/8, or odd tens digit with ones 2/6), and on day 28 otherwise.
- R7: The rollover out of December 31 gives January 1 and increments the year, and year 99 wraps to 00.
- R8: A load overwrites every field in one cycle and wins over a tick in the same cycle. Word layout: seconds [6:0], minutes [14:8], hours [21:16], weekday [26:24], day [33:28], month [40:36], year [51:44]. All other bits read as zero.
- R9: While hold is high, ticks leave the calendar unchanged. Counting resumes on the first tick after hold falls.
- R10: With the default divider, one tick occurs per 2^15 oscillator enables; in general the count is 2^(DIV_LO_BITS+DIV_HI_BITS). The 1 Hz output is low in the tick cycle and rises right after it.
- R11: A divider clear zeroes only the upper stages, so the next tick comes a full upper-stage period later, counted from the position of the lower stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| div_clr | input | 1 | Clears the 128 Hz to 1 Hz divider stages |
| hold | input | 1 | Keeps the second tick from reaching the calendar |
| load_en | input | 1 | Commits load_word to all fields |
| load_word | input | 52 | Parallel time and date to load |
| snap_word | output | 52 | Present time and date in frame order |
| sec_tick | output | 1 | One-cycle pulse per second |
| hz1_out | output | 1 | 1 Hz square wave aligned to the tick |

## Verification
A wrong carry or a wrong month-length decision does not show up until the next tick. It then appears at once in snap_word, as a day, month or year field that differs from the calendar rule. A divider fault shows up as a changed tick spacing after one second period. A fault in the hold gating, or in load priority, shows up in the word within one cycle of the tick that should have been blocked or overridden.

// File: rtl/rtccal_pkg.sv
package rtccal_pkg;
  localparam int FRAME_W = 52;

  typedef struct packed {
    logic [7:0] yr;
    logic [4:0] mo;
    logic [5:0] dy;
    logic [2:0] wk;
    logic [5:0] hr;
    logic [6:0] mi;
    logic [6:0] se;
  } cal_t;

  localparam cal_t CAL_RESET = '{yr: 8'h00, mo: 5'h01, dy: 6'h01, wk: 3'd1,
                                 hr: 6'h00, mi: 7'h00, se: 7'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [3:0] o;
    o = yr[3:0];
    if (!yr[4]) return (o == 4'd0) || (o == 4'd4) || (o == 4'd8);
    else        return (o == 4'd2) || (o == 4'd6);
  endfunction

  function automatic logic [5:0] last_day(input logic [4:0] mo, input logic leap);
    case (mo)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  function automatic logic [FRAME_W-1:0] pack_frame(input cal_t c);
    return {c.yr, 3'b0, c.mo, 2'b0, c.dy, 1'b0, c.wk, 2'b0, c.hr,
            1'b0, c.mi, 1'b0, c.se};
  endfunction

  function automatic cal_t unpack_frame(input logic [FRAME_W-1:0] w);
    cal_t c;
    c.se = w[6:0];
    c.mi = w[14:8];
    c.hr = w[21:16];
    c.wk = w[26:24];
    c.dy = w[33:28];
    c.mo = w[40:36];
    c.yr = w[51:44];
    return c;
  endfunction
endpackage

// File: rtl/rtccal_reset_sync.sv
module rtccal_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rtccal_prescaler.sv
module rtccal_prescaler #(
  parameter int DIV_LO_BITS = 8,
  parameter int DIV_HI_BITS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic div_clr,
  output logic tick,
  output logic hz1
);
  logic [DIV_LO_BITS-1:0] lo_q, lo_d;
  logic [DIV_HI_BITS-1:0] hi_q, hi_d;
  logic lo_carry;

  always_comb begin
    lo_carry = osc_en && (lo_q == '1);
    lo_d     = osc_en ? lo_q + 1'b1 : lo_q;
    if (div_clr)       hi_d = '0;
    else if (lo_carry) hi_d = hi_q + 1'b1;
    else               hi_d = hi_q;
    tick = lo_carry && (hi_q == '1) && !div_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign hz1 = ~hi_q[DIV_HI_BITS-1];

  a_r11_hi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    div_clr |=> (hi_q == '0));

  a_r10_tick_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (hi_q == '0) && (lo_q == '0));
endmodule

// File: rtl/rtccal_advance.sv
module rtccal_advance
  import rtccal_pkg::*;
(
  input  cal_t cur,
  output cal_t nxt,
  output logic day_roll
);
  logic c_s, c_m, c_h, c_d, c_mo, leap;
  logic [7:0] se_i, mi_i, hr_i, dy_i, mo_i, yr_i;

  always_comb begin
    leap = is_leap(cur.yr);
    c_s  = (cur.se == 7'h59);
    c_m  = c_s && (cur.mi == 7'h59);
    c_h  = c_m && (cur.hr == 6'h23);
    c_d  = c_h && (cur.dy == last_day(cur.mo, leap));
    c_mo = c_d && (cur.mo == 5'h12);

    se_i = bcd_inc({1'b0, cur.se});
    mi_i = bcd_inc({1'b0, cur.mi});
    hr_i = bcd_inc({2'b0, cur.hr});
    dy_i = bcd_inc({2'b0, cur.dy});
    mo_i = bcd_inc({3'b0, cur.mo});
    yr_i = bcd_inc(cur.yr);

    nxt    = cur;
    nxt.se = c_s ? 7'h00 : se_i[6:0];
    if (c_s) nxt.mi = c_m ? 7'h00 : mi_i[6:0];
    if (c_m) nxt.hr = c_h ? 6'h00 : hr_i[5:0];
    if (c_h) begin
      nxt.wk = (cur.wk == 3'd7) ? 3'd1 : cur.wk + 3'd1;
      nxt.dy = c_d ? 6'h01 : dy_i[5:0];
    end
    if (c_d)  nxt.mo = c_mo ? 5'h01 : mo_i[4:0];
    if (c_mo) nxt.yr = (cur.yr == 8'h99) ? 8'h00 : yr_i;
    day_roll = c_h;
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtccal_pkg::*;
#(
  parameter int DIV_LO_BITS = 8,
  parameter int DIV_HI_BITS = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               osc_en,
  input  logic               div_clr,
  input  logic               hold,
  input  logic               load_en,
  input  logic [FRAME_W-1:0] load_word,
  output logic [FRAME_W-1:0] snap_word,
  output logic               sec_tick,
  output logic               hz1_out
);
  logic rst_i;
  logic tick_raw, tick_g, day_roll;
  cal_t cal_q, cal_d, cal_adv;

  rtccal_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_i));

  rtccal_prescaler #(.DIV_LO_BITS(DIV_LO_BITS), .DIV_HI_BITS(DIV_HI_BITS)) u_div (
    .clk(clk), .rst_n(rst_i), .osc_en(osc_en), .div_clr(div_clr),
    .tick(tick_raw), .hz1(hz1_out));

  rtccal_advance u_adv (.cur(cal_q), .nxt(cal_adv), .day_roll(day_roll));

  always_comb begin
    tick_g = tick_raw && !hold;
    if (load_en)     cal_d = unpack_frame(load_word);
    else if (tick_g) cal_d = cal_adv;
    else             cal_d = cal_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) cal_q <= CAL_RESET;
    else        cal_q <= cal_d;
  end

  assign snap_word = pack_frame(cal_q);
  assign sec_tick  = tick_raw;

  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_i)
    (tick_g && !load_en && cal_q.se == 7'h59) |=> (snap_word[6:0] == 7'h00));

  a_r3_hour_wrap: assert property (@(posedge clk) disable iff (!rst_i)
    (tick_g && !load_en && day_roll) |=> (snap_word[21:0] == 22'h0));

  a_r4_week_wrap: assert property (@(posedge clk) disable iff (!rst_i)
    (tick_g && !load_en && day_roll && cal_q.wk == 3'd7) |=> (snap_word[26:24] == 3'd1));

  a_r7_year_wrap: assert property (@(posedge clk) disable iff (!rst_i)
    (tick_g && !load_en && day_roll && cal_q.mo == 5'h12 && cal_q.dy == 6'h31
     && cal_q.yr == 8'h99) |=> (snap_word[51:44] == 8'h00 && snap_word[40:36] == 5'h01));

  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_i)
    load_en |=> (snap_word == pack_frame(unpack_frame($past(load_word)))));

  a_r9_hold_freeze: assert property (@(posedge clk) disable iff (!rst_i)
    (hold && !load_en) |=> $stable(snap_word));
endmodule

// File: tb/rtc_calendar_core_bench.sv
module rtc_calendar_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_en = 1'b0;
  logic        div_clr = 1'b0;
  logic        hold = 1'b0;
  logic        load_en = 1'b0;
  logic [51:0] load_word = '0;
  logic [51:0] snap_word;
  logic        sec_tick, hz1_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_calendar_core #(.DIV_LO_BITS(2), .DIV_HI_BITS(3)) u_rtc_calendar_core (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .div_clr(div_clr), .hold(hold),
    .load_en(load_en), .load_word(load_word), .snap_word(snap_word),
    .sec_tick(sec_tick), .hz1_out(hz1_out));

  function automatic logic [51:0] mk(input logic [7:0] yr, input logic [7:0] mo,
      input logic [7:0] dy, input logic [2:0] wk, input logic [7:0] hr,
      input logic [7:0] mi, input logic [7:0] se);
    logic [51:0] w;
    w = '0;
    w[6:0] = se[6:0]; w[14:8] = mi[6:0]; w[21:16] = hr[5:0];
    w[26:24] = wk; w[33:28] = dy[5:0]; w[40:36] = mo[4:0]; w[51:44] = yr;
    return w;
  endfunction

  task automatic check(input string req, input logic [51:0] act, input logic [51:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [51:0] w);
    @(negedge clk); load_en = 1'b1; load_word = w;
    @(negedge clk); load_en = 1'b0;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!sec_tick);
  endtask

  task automatic roll(input string req, input logic [51:0] from, input logic [51:0] exp);
    load(from);
    wait_tick();
    @(negedge clk);
    check(req, snap_word, exp);
  endtask

  task automatic t_reset();
    check("R1 reset", snap_word, mk(8'h00, 8'h01, 8'h01, 3'd1, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic t_seconds();
    roll("R2 bcd 09->10", mk(8'h20, 8'h05, 8'h10, 3'd3, 8'h10, 8'h20, 8'h09),
         mk(8'h20, 8'h05, 8'h10, 3'd3, 8'h10, 8'h20, 8'h10));
    roll("R2 min carry", mk(8'h20, 8'h05, 8'h10, 3'd3, 8'h10, 8'h29, 8'h59),
         mk(8'h20, 8'h05, 8'h10, 3'd3, 8'h10, 8'h30, 8'h00));
  endtask

  task automatic t_days();
    roll("R3 midnight", mk(8'h21, 8'h03, 8'h14, 3'd2, 8'h23, 8'h59, 8'h59),
         mk(8'h21, 8'h03, 8'h15, 3'd3, 8'h00, 8'h00, 8'h00));
    roll("R4 week 7->1", mk(8'h21, 8'h03, 8'h19, 3'd7, 8'h23, 8'h59, 8'h59),
         mk(8'h21, 8'h03, 8'h20, 3'd1, 8'h00, 8'h00, 8'h00));
    roll("R5 apr 30", mk(8'h21, 8'h04, 8'h30, 3'd5, 8'h23, 8'h59, 8'h59),
         mk(8'h21, 8'h05, 8'h01, 3'd6, 8'h00, 8'h00, 8'h00));
    roll("R5 jan 31", mk(8'h21, 8'h01, 8'h31, 3'd4, 8'h23, 8'h59, 8'h59),
         mk(8'h21, 8'h02, 8'h01, 3'd5, 8'h00, 8'h00, 8'h00));
    roll("R5 jul 30 no wrap", mk(8'h21, 8'h07, 8'h30, 3'd4, 8'h23, 8'h59, 8'h59),
         mk(8'h21, 8'h07, 8'h31, 3'd5, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic t_leap();
    roll("R6 24 feb28", mk(8'h24, 8'h02, 8'h28, 3'd3, 8'h23, 8'h59, 8'h59),
         mk(8'h24, 8'h02, 8'h29, 3'd4, 8'h00, 8'h00, 8'h00));
    roll("R6 24 feb29", mk(8'h24, 8'h02, 8'h29, 3'd4, 8'h23, 8'h59, 8'h59),
         mk(8'h24, 8'h03, 8'h01, 3'd5, 8'h00, 8'h00, 8'h00));
    roll("R6 23 feb28", mk(8'h23, 8'h02, 8'h28, 3'd2, 8'h23, 8'h59, 8'h59),
         mk(8'h23, 8'h03, 8'h01, 3'd3, 8'h00, 8'h00, 8'h00));
    roll("R6 12 feb28", mk(8'h12, 8'h02, 8'h28, 3'd2, 8'h23, 8'h59, 8'h59),
         mk(8'h12, 8'h02, 8'h29, 3'd3, 8'h00, 8'h00, 8'h00));
    roll("R6 10 feb28", mk(8'h10, 8'h02, 8'h28, 3'd2, 8'h23, 8'h59, 8'h59),
         mk(8'h10, 8'h03, 8'h01, 3'd3, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic t_year();
    roll("R7 dec31 99", mk(8'h99, 8'h12, 8'h31, 3'd6, 8'h23, 8'h59, 8'h59),
         mk(8'h00, 8'h01, 8'h01, 3'd7, 8'h00, 8'h00, 8'h00));
    roll("R7 dec31 49", mk(8'h49, 8'h12, 8'h31, 3'd7, 8'h23, 8'h59, 8'h59),
         mk(8'h50, 8'h01, 8'h01, 3'd1, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic t_load();
    logic [51:0] w;
    w = mk(8'h35, 8'h08, 8'h17, 3'd2, 8'h11, 8'h45, 8'h30);
    hold = 1'b1;
    load(w | ~mk(8'hFF, 8'hFF, 8'hFF, 3'd7, 8'hFF, 8'hFF, 8'hFF));
    @(negedge clk);
    check("R8 unused bits zero", snap_word, w);
    hold = 1'b0;
    wait_tick();
    load_en = 1'b1; load_word = mk(8'h36, 8'h09, 8'h02, 3'd1, 8'h07, 8'h08, 8'h30);
    @(negedge clk); load_en = 1'b0;
    check("R8 load beats tick", snap_word, mk(8'h36, 8'h09, 8'h02, 3'd1, 8'h07, 8'h08, 8'h30));
  endtask

  task automatic t_hold();
    logic [51:0] w;
    w = mk(8'h40, 8'h06, 8'h06, 3'd6, 8'h06, 8'h06, 8'h58);
    load(w);
    hold = 1'b1;
    repeat (100) @(negedge clk);
    check("R9 frozen under hold", snap_word, w);
    hold = 1'b0;
    wait_tick();
    @(negedge clk);
    check("R9 resumes", snap_word, mk(8'h40, 8'h06, 8'h06, 3'd6, 8'h06, 8'h06, 8'h59));
  endtask

  task automatic t_divider();
    int c;
    wait_tick();
    check("R10 hz1 low at tick", {51'b0, hz1_out}, 52'd0);
    c = 0;
    do begin @(negedge clk); c++; if (c == 1) check("R10 hz1 rises", {51'b0, hz1_out}, 52'd1); end
    while (!sec_tick);
    check("R10 period", 52'(c), 52'd32);
    repeat (21) @(negedge clk);
    div_clr = 1'b1;
    @(negedge clk); div_clr = 1'b0;
    c = 0;
    while (!sec_tick) begin @(negedge clk); c++; end
    check("R11 clear delays tick", 52'(c), 52'd30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    osc_en = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_seconds();
    t_days();
    t_leap();
    t_year();
    t_load();
    t_hold();
    t_divider();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule